// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Interleaved Address Generator

This block is a behavioural synchronous static RAM of 18-bit words with a built-in two-bit burst address generator and two independently writable byte lanes. Every input apart from the output enable is sampled on the rising clock edge. Two address strobes can start an access, and they have fixed priority. The processor strobe, when qualified by chip enable, always starts a read. The controller strobe starts a read or a write, depending on the byte write enables. Once a base address is loaded, cycles with both strobes inactive either step through the burst or hold the current address. The advance input chooses which.

The burst steps through the two lowest address bits in interleaved order, so the low bits for step n equal the starting low bits XOR n. After four words the sequence wraps to the start. The bidirectional data pin is modelled as a write-data input, a read-data output and a read-valid flag. The output enable gates the valid flag without a clock. The word count is 2^ADDR_W. The default of 10 address bits keeps elaboration small, and a 15-bit setting gives 32768 words.

Top module: `sbsram_top`

## Requirements
- R1: When `proc_strb_n` and `ce_n` are both low at an edge, the burst restarts at `addr`, and that word is read. This happens regardless of `ctrl_strb_n` and `byte_wr_n`, and the memory is left unchanged.
- R2: When `ctrl_strb_n` is low, `proc_strb_n` is high and `ce_n` is low, the burst restarts at `addr`. The access is a write if either bit of `byte_wr_n` is low, and a read otherwise. A write produces no read output.
- R3: When `ctrl_strb_n` is low and `ce_n` is high, the block is deselected. No access takes place, and the burst ends, so later continue cycles do nothing until a new load.
- R4: When `ctrl_strb_n` is high and `ce_n` is high, `proc_strb_n` is ignored. No external address is registered, and the cycle continues or suspends the current burst.
- R5: In a cycle with no strobe active and `adv_n` low, the burst step increments before the access. The address used keeps the base's upper bits, and its low two bits are the base's low bits XOR the step, so the sequence wraps to the start after four words.
- R6: In a cycle with no strobe active and `adv_n` high, the current address is reused, which acts as a wait state. The access is a read or a write according to `byte_wr_n`.
- R7: `byte_wr_n[0]` low writes bits 8:0, and `byte_wr_n[1]` low writes bits 17:9. Either bit can be low on its own or together with the other, and a lane that is not enabled keeps its old contents.
- R8: A processor-strobe write takes two cycles. The first cycle loads the address with `proc_strb_n` low. In the second cycle both strobes are high, `adv_n` is high and a byte enable is low, and `wdata` is written to the loaded address.
- R9: Read data and `rdata_vld` appear after the edge that registered the read and hold until the next edge. A read of a word written at the previous edge returns the new value.
- R10: `rdata_vld` is high only after a read, and only while `oe_n` is low. A change of `oe_n` takes effect without a clock edge.
- R11: After reset no burst is active and `rdata_vld` is low. Continue or suspend cycles before the first load perform no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| wdata | input | 18 | Write data |
| ce_n | input | 1 | Chip enable, active low, looked at only on loads |
| proc_strb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| byte_wr_n | input | 2 | Lane write enables, active low; bit 0 covers bits 8:0, bit 1 covers bits 17:9 |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 18 | Read data |
| rdata_vld | output | 1 | Read data is being driven |

## Verification
Every access is decided at one edge, and its read result is visible from just after that edge until the next one. The bench therefore drives stimulus one time unit after a rising edge, waits for the next edge, and samples one time unit later, which checks results exactly one edge after the strobe. Writes are checked one edge later by a read, including the case of a read directly after a write. The output enable is checked by changing `oe_n` between edges and sampling after a short delay with no clock edge in between.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    localparam int LANE_W  = 9;
    localparam int LANES   = 2;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/sbsram_burst_ctrl.sv
module sbsram_burst_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic [LANES-1:0]  byte_wr_n,
    output logic [ADDR_W-1:0] acc_addr,
    output op_e               op,
    output logic [LANES-1:0]  lane_we
);
    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic               active;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic any_wr;
    logic proc_load;

    always_comb begin
        st_d      = st_q;
        op        = OP_NONE;
        lane_we   = '0;
        any_wr    = (byte_wr_n != {LANES{1'b1}});
        proc_load = !ce_n && !proc_strb_n;
        acc_addr  = {st_q.base[ADDR_W-1 -: HI_W], st_q.base[BURST_W-1:0] ^ st_q.cnt};
        if (proc_load) begin
            st_d.active = 1'b1;
            st_d.base   = addr_i;
            st_d.cnt    = '0;
            acc_addr    = addr_i;
            op          = OP_READ;
        end else if (!ctrl_strb_n) begin
            if (ce_n) begin
                st_d.active = 1'b0;
            end else begin
                st_d.active = 1'b1;
                st_d.base   = addr_i;
                st_d.cnt    = '0;
                acc_addr    = addr_i;
                if (any_wr) begin
                    op      = OP_WRITE;
                    lane_we = ~byte_wr_n;
                end else begin
                    op      = OP_READ;
                end
            end
        end else if (st_q.active) begin
            if (!adv_n) begin
                st_d.cnt = st_q.cnt + BURST_W'(1);
            end
            acc_addr = {st_q.base[ADDR_W-1 -: HI_W], st_q.base[BURST_W-1:0] ^ st_d.cnt};
            if (any_wr) begin
                op      = OP_WRITE;
                lane_we = ~byte_wr_n;
            end else begin
                op      = OP_READ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a continue cycle moves the step by exactly one
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && ctrl_strb_n && !adv_n && !(!ce_n && !proc_strb_n))
        |=> (st_q.cnt == $past(st_q.cnt) + BURST_W'(1)));

    // R6: a suspend cycle keeps base and step
    a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_strb_n && adv_n && !(!ce_n && !proc_strb_n))
        |=> ($stable(st_q.cnt) && $stable(st_q.base)));

    // R3: deselect ends the burst
    a_r3_desel_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !ctrl_strb_n) |=> !st_q.active);

    // R4: a processor strobe without chip enable registers no address
    a_r4_proc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && ctrl_strb_n) |=> $stable(st_q.base));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  op_e               op,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } out_t;

    logic [DATA_W-1:0] mem [DEPTH];
    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = (op == OP_READ);
        if (op == OP_READ) begin
            out_d.data = mem[acc_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_ff @(posedge clk) begin
        if (op == OP_WRITE) begin
            for (int g = 0; g < LANES; g++) begin
                if (lane_we[g]) begin
                    mem[acc_addr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rd_data = out_q.data;
    assign rd_vld  = out_q.vld;

    // R2: a write leaves no read result behind it
    a_r2_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> !out_q.vld);
endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [17:0]       wdata,
    input  logic              ce_n,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic [1:0]        byte_wr_n,
    input  logic              oe_n,
    output logic [17:0]       rdata,
    output logic              rdata_vld
);
    logic [ADDR_W-1:0] acc_addr;
    op_e               op;
    logic [LANES-1:0]  lane_we;
    logic              rd_vld;

    sbsram_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr),
        .ce_n        (ce_n),
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .adv_n       (adv_n),
        .byte_wr_n   (byte_wr_n),
        .acc_addr    (acc_addr),
        .op          (op),
        .lane_we     (lane_we)
    );

    sbsram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_addr (acc_addr),
        .op       (op),
        .lane_we  (lane_we),
        .wdata    (wdata),
        .rd_data  (rdata),
        .rd_vld   (rd_vld)
    );

    assign rdata_vld = rd_vld && !oe_n;

    // R1: a qualified processor strobe always produces a read
    a_r1_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !proc_strb_n) |=> rd_vld);

    // R3: a deselect cycle produces no read
    a_r3_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !ctrl_strb_n) |=> !rd_vld);
endmodule

// File: tb/sim_sbsram_top.sv
module sim_sbsram_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [17:0]   wdata = '0;
    logic          ce_n = 1'b1, proc_strb_n = 1'b1, ctrl_strb_n = 1'b1, adv_n = 1'b1, oe_n = 1'b0;
    logic [1:0]    byte_wr_n = 2'b11;
    logic [17:0]   rdata;
    logic          rdata_vld;

    logic [17:0] model [1 << AW];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbsram_top #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n),
        .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
        .byte_wr_n(byte_wr_n), .oe_n(oe_n), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    task automatic chk_vld(string tag, logic exp);
        n_chk++;
        if (rdata_vld !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata_vld=%b expected %b", tag, rdata_vld, exp);
        end
    endtask

    task automatic chk_rd(string tag, logic [17:0] exp);
        n_chk++;
        if (rdata_vld !== 1'b1 || rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: vld=%b data=%h expected vld=1 data=%h", tag, rdata_vld, rdata, exp);
        end
    endtask

    // one edge with the given inputs; returns 1 time unit after the edge
    task automatic step(logic p, logic c, logic a, logic ce, logic [1:0] bw,
                        logic [AW-1:0] ad, logic [17:0] d);
        proc_strb_n = p; ctrl_strb_n = c; adv_n = a; ce_n = ce;
        byte_wr_n = bw; addr = ad; wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic ctrl_write(logic [AW-1:0] ad, logic [17:0] d, logic [1:0] bw);
        step(1, 0, 1, 0, bw, ad, d);
        if (!bw[0]) model[ad][8:0]  = d[8:0];
        if (!bw[1]) model[ad][17:9] = d[17:9];
    endtask

    task automatic deselect();
        step(1, 0, 1, 1, 2'b11, '0, '0);
    endtask

    task automatic t_reset();
        chk_vld("R11 reset", 1'b0);
        step(1, 1, 0, 0, 2'b11, '0, '0);
        chk_vld("R11 continue before load", 1'b0);
        step(1, 1, 1, 0, 2'b11, '0, '0);
        chk_vld("R11 suspend before load", 1'b0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 64; i++) begin
            ctrl_write(AW'(i), 18'((i * 18'h0137) ^ 18'h2A5A5), 2'b00);
            if (i == 0) chk_vld("R2 write gives no read", 1'b0);
        end
        deselect();
    endtask

    task automatic t_ctrl_read();
        step(1, 0, 1, 0, 2'b11, 10'd5, '0);
        chk_rd("R2 controller read", model[5]);
        step(1, 0, 1, 0, 2'b11, 10'd6, '0);
        chk_rd("R9 back-to-back read", model[6]);
        deselect();
    endtask

    task automatic t_proc_read();
        step(0, 0, 1, 0, 2'b00, 10'd9, 18'h3FFFF);
        chk_rd("R1 processor read ignores enables", model[9]);
        deselect();
        step(1, 0, 1, 0, 2'b11, 10'd9, '0);
        chk_rd("R1 memory unchanged", model[9]);
        deselect();
    endtask

    task automatic t_burst();
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] b;
            b = AW'(16 + s);
            step(0, 1, 1, 0, 2'b11, b, '0);
            chk_rd("R5 burst start", model[b]);
            for (int n = 1; n <= 4; n++) begin
                logic [AW-1:0] e;
                e = {b[AW-1:2], 2'(s ^ (n % 4))};
                step(1, 1, 0, 1, 2'b11, '0, '0);
                chk_rd("R5 interleaved step", model[e]);
            end
            deselect();
        end
    endtask

    task automatic t_suspend();
        step(0, 1, 1, 0, 2'b11, 10'd33, '0);
        step(1, 1, 1, 0, 2'b11, '0, '0);
        chk_rd("R6 wait state 1", model[33]);
        step(1, 1, 1, 1, 2'b11, '0, '0);
        chk_rd("R6 wait state 2", model[33]);
        step(1, 1, 0, 0, 2'b11, '0, '0);
        chk_rd("R5 step after wait", model[32]);
        step(1, 1, 1, 0, 2'b01, '0, 18'h15555);
        model[32][17:9] = 9'h0AA;
        chk_vld("R6 suspend write", 1'b0);
        step(1, 1, 1, 0, 2'b11, '0, '0);
        chk_rd("R6 suspend write landed", model[32]);
        deselect();
    endtask

    task automatic t_bytes();
        ctrl_write(10'd40, 18'h3FE01, 2'b10);
        step(1, 0, 1, 0, 2'b11, 10'd40, '0);
        chk_rd("R7 lower lane only", model[40]);
        ctrl_write(10'd40, 18'h0A5FF, 2'b01);
        step(1, 0, 1, 0, 2'b11, 10'd40, '0);
        chk_rd("R7 upper lane only", model[40]);
        deselect();
    endtask

    task automatic t_proc_write();
        step(0, 1, 1, 0, 2'b11, 10'd50, '0);
        chk_rd("R8 first cycle reads", model[50]);
        step(1, 1, 1, 1, 2'b00, 10'd3, 18'h2468A);
        model[50] = 18'h2468A;
        chk_vld("R8 second cycle writes", 1'b0);
        step(1, 0, 1, 0, 2'b11, 10'd50, '0);
        chk_rd("R8 written word", 18'h2468A);
        ctrl_write(10'd51, 18'h13579, 2'b00);
        step(1, 0, 1, 0, 2'b11, 10'd51, '0);
        chk_rd("R9 read after write", 18'h13579);
        deselect();
    endtask

    task automatic t_burst_write();
        ctrl_write(10'd58, 18'h11111, 2'b00);
        step(1, 1, 0, 0, 2'b00, '0, 18'h22222);
        model[59] = 18'h22222;
        step(1, 1, 0, 0, 2'b00, '0, 18'h33333);
        model[56] = 18'h33333;
        step(1, 0, 1, 0, 2'b11, 10'd59, '0);
        chk_rd("R5 burst write step 1", 18'h22222);
        step(1, 0, 1, 0, 2'b11, 10'd56, '0);
        chk_rd("R5 burst write step 2", 18'h33333);
        deselect();
    endtask

    task automatic t_desel();
        step(0, 1, 1, 0, 2'b11, 10'd12, '0);
        deselect();
        chk_vld("R3 deselect no read", 1'b0);
        step(1, 1, 0, 0, 2'b11, '0, '0);
        chk_vld("R3 burst ended", 1'b0);
    endtask

    task automatic t_ignore();
        step(0, 1, 1, 0, 2'b11, 10'd20, '0);
        step(0, 1, 0, 1, 2'b11, 10'd7, '0);
        chk_rd("R4 processor strobe ignored", model[21]);
        deselect();
    endtask

    task automatic t_oe();
        step(1, 0, 1, 0, 2'b11, 10'd30, '0);
        chk_rd("R10 enabled", model[30]);
        #1 oe_n = 1'b1;
        #1 chk_vld("R10 disabled without clock", 1'b0);
        #1 oe_n = 1'b0;
        #1 chk_rd("R10 re-enabled", model[30]);
        deselect();
    endtask

    initial begin
        #(CLK_PERIOD * 3 + 1);
        t_reset();
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_fill();
        t_ctrl_read();
        t_proc_read();
        t_burst();
        t_suspend();
        t_bytes();
        t_proc_write();
        t_burst_write();
        t_desel();
        t_ignore();
        t_oe();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule